// File: doc/BRIEF.md
# Circulating Serial Register Transfer

This block copies the contents of one 4-bit register into another, one bit per clock, through a single serial line. A source register and a destination register both shift right while a small sequencer holds their shift enable. The bit leaving the right end of the source goes to two places. It enters the left end of the destination, and it is also written back into the left end of the source. After one complete transfer, the destination therefore holds the source's value and the source still holds its own.

Both registers can be loaded in parallel while the unit is idle. This lets a test or a surrounding controller set up their contents. A start request makes the sequencer assert its shift enable for exactly as many clock cycles as the register width. It then drops the enable and raises a one-cycle done pulse. Every change happens on the rising edge of one clock with a synchronous enable, so a partial shift cannot occur.

Top module: `xfer_circ_top`

## Requirements
- R1: While rst_ni is low, reg_a_o, reg_b_o, busy_o and done_o are all 0.
- R2: When the unit is idle, load_a_i writes din_a_i into reg_a_o at the next rising edge and load_b_i writes din_b_i into reg_b_o. The two loads are independent, and both may occur in the same cycle.
- R3: When the unit is idle, a start_i with both load inputs low makes busy_o high from the next cycle for exactly 4 consecutive cycles.
- R4: Each cycle with busy_o high shifts both registers right by one bit, where bit 3 is the leftmost bit and bit 0 the rightmost. Source bit 0 enters bit 3 of both registers, and the old destination bit 0 is discarded. Starting from source 1011 and destination 0010, bit 3 of the destination is 1 after the first shift.
- R5: After the fourth shift, reg_b_o equals the value reg_a_o had at start, and reg_a_o is unchanged (1011 and 0010 give 1011 and 1011).
- R6: done_o is high for exactly one cycle, in the cycle right after the fourth shift (the first cycle with busy_o low again), and at no other time.
- R7: A start_i while busy_o is high is ignored: the transfer still ends 4 cycles after the accepted start, and only one done pulse is produced.
- R8: load_a_i and load_b_i while busy_o is high are ignored: the shifting proceeds as if no load had been requested.
- R9: If a load and start_i arrive together while idle, the load is performed and the start is dropped, so busy_o stays low.
- R10: While idle with no load requested, both registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to begin a transfer |
| load_a_i | input | 1 | Parallel load of the source register |
| load_b_i | input | 1 | Parallel load of the destination register |
| din_a_i | input | 4 | Parallel data for the source |
| din_b_i | input | 4 | Parallel data for the destination |
| reg_a_o | output | 4 | Source register contents |
| reg_b_o | output | 4 | Destination register contents |
| busy_o | output | 1 | Shift enable, high during the four shift cycles |
| done_o | output | 1 | One-cycle pulse after the last shift |

## Verification
The transfer is first run with source 1011 and destination 0010. With these values, a mistake in shift direction, in the feedback into the source or in the bit count leaves a different final pattern, and a wrong first shift is seen in the destination's top bit. A sweep of source values against complemented destinations then shows that the destination's old bits are lost and do not leak back. Further runs add start and load pulses while busy, and a load issued together with a start. These separate "ignored" from "restarted" or "overwritten". An idle stretch with no stimulus confirms that both registers hold their values.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } xfer_state_e;
endpackage

// File: rtl/xfer_shreg.sv
module xfer_shreg #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             shift_i,
  input  logic             si_i,
  output logic [WIDTH-1:0] q_o,
  output logic             so_o
);
  logic [WIDTH-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_q <= '0;
    else if (load_i)  q_q <= din_i;
    else if (shift_i) q_q <= {si_i, q_q[WIDTH-1:1]};
  end

  assign q_o  = q_q;
  assign so_o = q_q[0];

  // R2
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> q_o == $past(din_i));
  // R4
  shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i) |=> q_o == {$past(si_i), $past(q_o[WIDTH-1:1])});
  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_i && !load_i) |=> $stable(q_o));
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import xfer_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic load_req_i,
  output logic shift_o,
  output logic done_o
);
  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WIDTH - 1);

  xfer_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             accept, last;

  // load wins over start
  assign accept = (state_q == ST_IDLE) && start_i && !load_req_i;
  assign last   = (cnt_q == LAST_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_SHIFT;
            cnt_q   <= '0;
          end
        end
        ST_SHIFT: begin
          cnt_q <= cnt_q + 1'b1;
          if (last) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign shift_o = (state_q == ST_SHIFT);
  assign done_o  = done_q;

  // R3
  start_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> shift_o && cnt_q == '0);
  // R3
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_o && !last) |=> shift_o);
  // R7
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_o && start_i && !last) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R6
  done_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(shift_o) |-> done_o);
  // R9
  load_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_o && load_req_i) |=> !shift_o);
endmodule

// File: rtl/xfer_circ_top.sv
module xfer_circ_top #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             load_a_i,
  input  logic             load_b_i,
  input  logic [WIDTH-1:0] din_a_i,
  input  logic [WIDTH-1:0] din_b_i,
  output logic [WIDTH-1:0] reg_a_o,
  output logic [WIDTH-1:0] reg_b_o,
  output logic             busy_o,
  output logic             done_o
);
  logic shift_en, so_a, so_b;
  logic load_a_en, load_b_en;

  // loads only while idle
  assign load_a_en = load_a_i && !shift_en;
  assign load_b_en = load_b_i && !shift_en;

  xfer_seq #(.WIDTH(WIDTH)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .load_req_i (load_a_i || load_b_i),
    .shift_o    (shift_en),
    .done_o     (done_o)
  );

  // source recirculates its own serial output
  xfer_shreg #(.WIDTH(WIDTH)) u_src (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_a_en),
    .din_i   (din_a_i),
    .shift_i (shift_en),
    .si_i    (so_a),
    .q_o     (reg_a_o),
    .so_o    (so_a)
  );

  xfer_shreg #(.WIDTH(WIDTH)) u_dst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_b_en),
    .din_i   (din_b_i),
    .shift_i (shift_en),
    .si_i    (so_a),
    .q_o     (reg_b_o),
    .so_o    (so_b)
  );

  assign busy_o = shift_en;

  // R5 (four shifts: literal depth matches the default width)
  xfer_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (reg_b_o == reg_a_o) && (reg_a_o == $past(reg_a_o, 4)));
  // R8
  busy_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && load_a_i) |=> reg_a_o == {$past(so_a), $past(reg_a_o[WIDTH-1:1])});
  // R4
  dst_feed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> reg_b_o[WIDTH-1] == $past(reg_a_o[0]));
  // R1
  rst_idle_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !busy_o && !done_o && reg_a_o == '0 && reg_b_o == '0);
endmodule

// File: tb/xfer_circ_top_tb.sv
module xfer_circ_top_tb;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0, load_a = 1'b0, load_b = 1'b0;
  logic [W-1:0] din_a = '0, din_b = '0;
  logic [W-1:0] reg_a, reg_b;
  logic         busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  xfer_circ_top #(.WIDTH(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .load_a_i(load_a), .load_b_i(load_b),
    .din_a_i(din_a), .din_b_i(din_b),
    .reg_a_o(reg_a), .reg_b_o(reg_b), .busy_o(busy), .done_o(done)
  );

  typedef struct {
    string        tag;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         bsy;
    logic         dn;
  } exp_t;

  exp_t exp_q[$];

  // reference state, built from the requirements
  logic [W-1:0] m_a = '0, m_b = '0;
  logic         m_busy = 0, m_done = 0;
  int           m_cnt = 0;

  task automatic step(input logic st, input logic la, input logic lb,
                      input logic [W-1:0] da, input logic [W-1:0] db,
                      input string tag);
    exp_t e;
    logic sbit;
    @(negedge clk);
    start = st; load_a = la; load_b = lb; din_a = da; din_b = db;
    if (m_busy) begin
      sbit = m_a[0];
      m_a = {sbit, m_a[W-1:1]};
      m_b = {sbit, m_b[W-1:1]};
      m_cnt++;
      m_done = (m_cnt == W);
      if (m_cnt == W) m_busy = 0;
    end else begin
      m_done = 0;
      if (la) m_a = da;
      if (lb) m_b = db;
      if (st && !la && !lb) begin m_busy = 1; m_cnt = 0; end
    end
    e.tag = tag; e.a = m_a; e.b = m_b; e.bsy = m_busy; e.dn = m_done;
    exp_q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, '0, '0, tag);
  endtask

  // monitor: scoreboard compare after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (reg_a !== e.a || reg_b !== e.b || busy !== e.bsy || done !== e.dn) begin
          errors++;
          $display("FAIL %s: got a=%b b=%b busy=%b done=%b exp a=%b b=%b busy=%b done=%b",
                   e.tag, reg_a, reg_b, busy, done, e.a, e.b, e.bsy, e.dn);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #12;
    checks++;
    if (reg_a !== '0 || reg_b !== '0 || busy !== 0 || done !== 0) begin
      errors++;
      $display("FAIL R1: got a=%b b=%b busy=%b done=%b exp all zero", reg_a, reg_b, busy, done);
    end
    @(negedge clk); rst_n = 1'b1;

    // R2 parallel loads, R10 hold
    step(0, 1, 0, 4'b1011, 4'b1111, "R2 load a");
    step(0, 0, 1, 4'b0000, 4'b0010, "R2 load b");
    idle("R10 hold");
    idle("R10 hold");

    // R3/R4/R5/R6 reference transfer 1011 -> 0010
    step(1, 0, 0, '0, '0, "R3 start");
    idle("R4 first shift, b msb=1");
    idle("R4 shift");
    idle("R4 shift");
    idle("R5 final shift 1011/1011");
    idle("R6 done cleared");
    idle("R10 hold after transfer");

    // R7 start during busy, R8 loads during busy
    step(0, 1, 1, 4'b0110, 4'b1001, "R2 dual load");
    step(1, 0, 0, '0, '0, "R3 start");
    step(1, 0, 0, '0, '0, "R7 start while busy");
    step(0, 1, 0, 4'b1111, 4'b0000, "R8 load a while busy");
    step(0, 0, 1, 4'b0000, 4'b1111, "R8 load b while busy");
    step(1, 1, 1, 4'b0101, 4'b0101, "R7 R8 last shift");
    idle("R6 done once");
    idle("R7 no restart");

    // R9 load with start
    step(1, 1, 0, 4'b1100, 4'b0000, "R9 load beats start");
    idle("R9 stays idle");
    step(1, 0, 1, 4'b0000, 4'b0011, "R9 load b beats start");
    idle("R9 stays idle");

    // sweep: source against complemented destination
    for (int v = 0; v < 16; v++) begin
      step(0, 1, 1, 4'(v), ~4'(v), "R2 sweep load");
      step(1, 0, 0, '0, '0, "R3 sweep start");
      for (int k = 0; k < W; k++) idle("R4 R5 sweep shift");
      idle("R6 sweep done");
    end

    // back-to-back: start in the done cycle
    step(1, 0, 0, '0, '0, "R3 start");
    for (int k = 0; k < W; k++) idle("R4 shift");
    step(1, 0, 0, '0, '0, "R3 start in done cycle");
    for (int k = 0; k < W + 2; k++) idle("R6 R10 tail");

    @(posedge clk); #3;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule